// File: doc/BRIEF.md
# Interrupt Pin Capture and Dispatch Scanner

This block samples a set of external interrupt lines, records a request bit per line, and hands pending requests one at a time to a downstream delivery agent. Each line has a redirection entry, supplied on configuration inputs. The entry holds a mask, a trigger kind (level or edge), a vector, a destination, a delivery mode, a destination mode and a polarity flag. Edge lines keep their request until it is delivered. Level lines mirror the line itself.

A fresh request starts a scan. The scan walks the lines from index 0 upward and skips masked lines. For each pending line it raises a request carrying that line's entry fields, then waits for the agent to accept or reject it. An accept retires an edge request. A reject marks the entry as stalled and leaves the request in place, so the next scan tries it again. Successive rejects are counted, and a warning output rises once the count passes a limit. An entry using the external-controller mode (code 7) is never sent, and it raises a sticky error flag instead.

Top module: `irq_dispatch_scanner`

## Requirements
- R1: After reset, pending_o, dlv_status_o, req_valid_o, stuck_warn_o and mode_err_o are all 0.
- R2: For a line with cfg_level_i=1, pending_o follows irq_pin_i one cycle later, and an accepted delivery leaves it set while the line stays high.
- R3: For a line with cfg_level_i=0, a low-to-high change of irq_pin_i sets its pending bit. A return to low leaves the bit set, and an accepted delivery of that line clears it.
- R4: A pending bit newly set by a rising line starts a scan. Pending lines are requested in ascending index order.
- R5: A line whose cfg_mask_i bit is 1 is never requested, and its pending bit stays set.
- R6: While req_valid_o is high and no response has arrived, every req_* output holds its value. A response (one-cycle rsp_accept_i or rsp_reject_i) drops req_valid_o at the next cycle, so at most one request is outstanding.
- R7: An accept clears the line's dlv_status_o bit and resets the reject counter, so stuck_warn_o is 0 afterwards.
- R8: A reject sets the line's dlv_status_o bit, keeps its pending bit for a later scan, and increments the reject counter. stuck_warn_o is 1 once the counter exceeds STUCK_LIMIT (default 5), that is, after the sixth reject in a row with no accept between.
- R9: A pending unmasked line whose delivery mode field is 3'd7 is not requested. It sets mode_err_o, which stays at 1 until reset, and the line's pending bit stays set.
- R10: A scan start that arrives while a scan is running is remembered, and a full scan from index 0 follows when the current one completes.
- R11: Line i's entry is read from slices [i*8 +: 8] of cfg_vector_i and cfg_dest_i, from [i*3 +: 3] of cfg_dlv_mode_i, and from bit i of cfg_dest_mode_i, cfg_polarity_i and cfg_level_i. The request presents these fields unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_pin_i | input | NUM_PINS | Interrupt lines, synchronous to clk |
| cfg_mask_i | input | NUM_PINS | 1 = line masked |
| cfg_level_i | input | NUM_PINS | 1 = level trigger, 0 = edge trigger |
| cfg_polarity_i | input | NUM_PINS | Polarity flag passed to the request |
| cfg_dest_mode_i | input | NUM_PINS | Destination mode passed to the request |
| cfg_dlv_mode_i | input | 3*NUM_PINS | Delivery mode per line, 7 = external controller |
| cfg_vector_i | input | VEC_W*NUM_PINS | Vector per line |
| cfg_dest_i | input | DEST_W*NUM_PINS | Destination per line |
| req_valid_o | output | 1 | Request outstanding |
| req_vector_o | output | VEC_W | Requested vector |
| req_dest_o | output | DEST_W | Requested destination |
| req_dlv_mode_o | output | 3 | Requested delivery mode |
| req_dest_mode_o | output | 1 | Requested destination mode |
| req_polarity_o | output | 1 | Requested polarity flag |
| req_level_o | output | 1 | Trigger kind of the requested line |
| rsp_accept_i | input | 1 | One-cycle accept of the outstanding request |
| rsp_reject_i | input | 1 | One-cycle reject of the outstanding request |
| pending_o | output | NUM_PINS | Per-line request bits |
| dlv_status_o | output | NUM_PINS | Per-line stalled-delivery flags |
| stuck_warn_o | output | 1 | Reject counter above STUCK_LIMIT |
| mode_err_o | output | 1 | Sticky unsupported-mode flag |

## Verification
On every cycle the assertions check several properties. A level line's pending bit must track the line. An edge request may fall only after an accept. The request must hold steady until a response arrives, and a response must retire it. Mode 7 never appears on a new request, the warning rises only after a reject and falls after an accept, and the error flag stays set. Only the bench scenarios can show the rest: the ascending delivery order, masked lines being skipped, a start arriving mid-scan causing a second pass, and rejected requests being retried until the warning threshold is crossed.

// File: rtl/irq_dispatch_pkg.sv
package irq_dispatch_pkg;
    localparam int unsigned DLV_MODE_W = 3;
    localparam logic [DLV_MODE_W-1:0] DLV_EXTERNAL = 3'd7;

    typedef enum logic [1:0] {
        SC_IDLE = 2'd0,
        SC_SCAN = 2'd1,
        SC_WAIT = 2'd2
    } scan_state_e;
endpackage

// File: rtl/irq_pin_capture.sv
module irq_pin_capture #(
    parameter int unsigned NUM_PINS = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] pin_i,
    input  logic [NUM_PINS-1:0] level_i,
    input  logic [NUM_PINS-1:0] clr_pend_i,
    output logic [NUM_PINS-1:0] pend_o,
    output logic                scan_start_o
);
    typedef struct packed {
        logic [NUM_PINS-1:0] line;
        logic [NUM_PINS-1:0] pend;
    } cap_s;

    cap_s cap_d, cap_q;
    logic [NUM_PINS-1:0] rise;

    assign rise = pin_i & ~cap_q.line;

    for (genvar g = 0; g < NUM_PINS; g++) begin : g_line
        always_comb begin
            if (level_i[g]) begin
                cap_d.pend[g] = pin_i[g];
            end else begin
                cap_d.pend[g] = (cap_q.pend[g] & ~clr_pend_i[g]) | rise[g];
            end
            cap_d.line[g] = pin_i[g];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cap_q <= '0;
        else        cap_q <= cap_d;
    end

    assign pend_o       = cap_q.pend;
    assign scan_start_o = |rise;
endmodule

// File: rtl/irq_scan_ctrl.sv
module irq_scan_ctrl
    import irq_dispatch_pkg::*;
#(
    parameter int unsigned NUM_PINS = 8,
    parameter int unsigned VEC_W    = 8,
    parameter int unsigned DEST_W   = 8
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [NUM_PINS-1:0]            pend_i,
    input  logic                           scan_start_i,
    input  logic [NUM_PINS-1:0]            cfg_mask_i,
    input  logic [NUM_PINS-1:0]            cfg_level_i,
    input  logic [NUM_PINS-1:0]            cfg_polarity_i,
    input  logic [NUM_PINS-1:0]            cfg_dest_mode_i,
    input  logic [DLV_MODE_W*NUM_PINS-1:0] cfg_dlv_mode_i,
    input  logic [VEC_W*NUM_PINS-1:0]      cfg_vector_i,
    input  logic [DEST_W*NUM_PINS-1:0]     cfg_dest_i,
    input  logic                           rsp_accept_i,
    input  logic                           rsp_reject_i,
    output logic                           req_valid_o,
    output logic [VEC_W-1:0]               req_vector_o,
    output logic [DEST_W-1:0]              req_dest_o,
    output logic [DLV_MODE_W-1:0]          req_dlv_mode_o,
    output logic                           req_dest_mode_o,
    output logic                           req_polarity_o,
    output logic                           req_level_o,
    output logic [NUM_PINS-1:0]            clr_pend_o,
    output logic [NUM_PINS-1:0]            status_o,
    output logic                           mode_err_o,
    output logic                           deliver_ok_o,
    output logic                           deliver_fail_o
);
    localparam int unsigned IDX_W = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_PINS - 1);

    typedef struct packed {
        scan_state_e           state;
        logic [IDX_W-1:0]      idx;
        logic                  again;
        logic [VEC_W-1:0]      vector;
        logic [DEST_W-1:0]     dest;
        logic [DLV_MODE_W-1:0] dlv_mode;
        logic                  dest_mode;
        logic                  polarity;
        logic                  level;
        logic [NUM_PINS-1:0]   status;
        logic                  mode_err;
    } scan_s;

    scan_s scan_d, scan_q;
    logic  step;
    logic  [DLV_MODE_W-1:0] cur_mode;

    always_comb begin
        scan_d         = scan_q;
        step           = 1'b0;
        clr_pend_o     = '0;
        deliver_ok_o   = 1'b0;
        deliver_fail_o = 1'b0;
        cur_mode       = cfg_dlv_mode_i[scan_q.idx*DLV_MODE_W +: DLV_MODE_W];

        case (scan_q.state)
            SC_IDLE: begin
                scan_d.again = 1'b0;
                if (scan_start_i) begin
                    scan_d.state = SC_SCAN;
                    scan_d.idx   = '0;
                end
            end
            SC_SCAN: begin
                if (scan_start_i) scan_d.again = 1'b1;
                if (pend_i[scan_q.idx] && !cfg_mask_i[scan_q.idx]) begin
                    if (cur_mode == DLV_EXTERNAL) begin
                        scan_d.mode_err = 1'b1;
                        step            = 1'b1;
                    end else begin
                        scan_d.state     = SC_WAIT;
                        scan_d.vector    = cfg_vector_i[scan_q.idx*VEC_W +: VEC_W];
                        scan_d.dest      = cfg_dest_i[scan_q.idx*DEST_W +: DEST_W];
                        scan_d.dlv_mode  = cur_mode;
                        scan_d.dest_mode = cfg_dest_mode_i[scan_q.idx];
                        scan_d.polarity  = cfg_polarity_i[scan_q.idx];
                        scan_d.level     = cfg_level_i[scan_q.idx];
                    end
                end else begin
                    step = 1'b1;
                end
            end
            SC_WAIT: begin
                if (scan_start_i) scan_d.again = 1'b1;
                if (rsp_accept_i) begin
                    deliver_ok_o                 = 1'b1;
                    clr_pend_o[scan_q.idx]       = ~scan_q.level;
                    scan_d.status[scan_q.idx]    = 1'b0;
                    step                         = 1'b1;
                end else if (rsp_reject_i) begin
                    deliver_fail_o               = 1'b1;
                    scan_d.status[scan_q.idx]    = 1'b1;
                    step                         = 1'b1;
                end
            end
            default: scan_d.state = SC_IDLE;
        endcase

        if (step) begin
            if (scan_q.idx == LAST_IDX) begin
                if (scan_d.again) begin
                    scan_d.state = SC_SCAN;
                    scan_d.idx   = '0;
                    scan_d.again = 1'b0;
                end else begin
                    scan_d.state = SC_IDLE;
                end
            end else begin
                scan_d.state = SC_SCAN;
                scan_d.idx   = scan_q.idx + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) scan_q <= '0;
        else        scan_q <= scan_d;
    end

    assign req_valid_o     = (scan_q.state == SC_WAIT);
    assign req_vector_o    = scan_q.vector;
    assign req_dest_o      = scan_q.dest;
    assign req_dlv_mode_o  = scan_q.dlv_mode;
    assign req_dest_mode_o = scan_q.dest_mode;
    assign req_polarity_o  = scan_q.polarity;
    assign req_level_o     = scan_q.level;
    assign status_o        = scan_q.status;
    assign mode_err_o      = scan_q.mode_err;
endmodule

// File: rtl/irq_stuck_tracker.sv
module irq_stuck_tracker #(
    parameter int unsigned STUCK_LIMIT = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ok_i,
    input  logic fail_i,
    output logic warn_o
);
    localparam int unsigned CNT_W = $clog2(STUCK_LIMIT + 2);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } stuck_s;

    stuck_s stk_d, stk_q;

    always_comb begin
        stk_d = stk_q;
        if (ok_i) begin
            stk_d.cnt = '0;
        end else if (fail_i && (stk_q.cnt != CNT_MAX)) begin
            stk_d.cnt = stk_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stk_q <= '0;
        else        stk_q <= stk_d;
    end

    assign warn_o = (stk_q.cnt > CNT_W'(STUCK_LIMIT));
endmodule

// File: rtl/irq_dispatch_scanner.sv
module irq_dispatch_scanner
    import irq_dispatch_pkg::*;
#(
    parameter int unsigned NUM_PINS    = 8,
    parameter int unsigned VEC_W       = 8,
    parameter int unsigned DEST_W      = 8,
    parameter int unsigned STUCK_LIMIT = 5
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [NUM_PINS-1:0]            irq_pin_i,
    input  logic [NUM_PINS-1:0]            cfg_mask_i,
    input  logic [NUM_PINS-1:0]            cfg_level_i,
    input  logic [NUM_PINS-1:0]            cfg_polarity_i,
    input  logic [NUM_PINS-1:0]            cfg_dest_mode_i,
    input  logic [DLV_MODE_W*NUM_PINS-1:0] cfg_dlv_mode_i,
    input  logic [VEC_W*NUM_PINS-1:0]      cfg_vector_i,
    input  logic [DEST_W*NUM_PINS-1:0]     cfg_dest_i,
    output logic                           req_valid_o,
    output logic [VEC_W-1:0]               req_vector_o,
    output logic [DEST_W-1:0]              req_dest_o,
    output logic [DLV_MODE_W-1:0]          req_dlv_mode_o,
    output logic                           req_dest_mode_o,
    output logic                           req_polarity_o,
    output logic                           req_level_o,
    input  logic                           rsp_accept_i,
    input  logic                           rsp_reject_i,
    output logic [NUM_PINS-1:0]            pending_o,
    output logic [NUM_PINS-1:0]            dlv_status_o,
    output logic                           stuck_warn_o,
    output logic                           mode_err_o
);
    logic [NUM_PINS-1:0] clr_pend;
    logic                scan_start;
    logic                deliver_ok;
    logic                deliver_fail;

    irq_pin_capture #(.NUM_PINS(NUM_PINS)) u_capture (
        .clk          (clk),
        .rst_n        (rst_n),
        .pin_i        (irq_pin_i),
        .level_i      (cfg_level_i),
        .clr_pend_i   (clr_pend),
        .pend_o       (pending_o),
        .scan_start_o (scan_start)
    );

    irq_scan_ctrl #(
        .NUM_PINS (NUM_PINS),
        .VEC_W    (VEC_W),
        .DEST_W   (DEST_W)
    ) u_scan (
        .clk             (clk),
        .rst_n           (rst_n),
        .pend_i          (pending_o),
        .scan_start_i    (scan_start),
        .cfg_mask_i      (cfg_mask_i),
        .cfg_level_i     (cfg_level_i),
        .cfg_polarity_i  (cfg_polarity_i),
        .cfg_dest_mode_i (cfg_dest_mode_i),
        .cfg_dlv_mode_i  (cfg_dlv_mode_i),
        .cfg_vector_i    (cfg_vector_i),
        .cfg_dest_i      (cfg_dest_i),
        .rsp_accept_i    (rsp_accept_i),
        .rsp_reject_i    (rsp_reject_i),
        .req_valid_o     (req_valid_o),
        .req_vector_o    (req_vector_o),
        .req_dest_o      (req_dest_o),
        .req_dlv_mode_o  (req_dlv_mode_o),
        .req_dest_mode_o (req_dest_mode_o),
        .req_polarity_o  (req_polarity_o),
        .req_level_o     (req_level_o),
        .clr_pend_o      (clr_pend),
        .status_o        (dlv_status_o),
        .mode_err_o      (mode_err_o),
        .deliver_ok_o    (deliver_ok),
        .deliver_fail_o  (deliver_fail)
    );

    irq_stuck_tracker #(.STUCK_LIMIT(STUCK_LIMIT)) u_stuck (
        .clk    (clk),
        .rst_n  (rst_n),
        .ok_i   (deliver_ok),
        .fail_i (deliver_fail),
        .warn_o (stuck_warn_o)
    );
endmodule

// File: rtl/irq_dispatch_scanner_chk.sv
module irq_dispatch_scanner_chk #(
    parameter int unsigned NUM_PINS = 8,
    parameter int unsigned VEC_W    = 8,
    parameter int unsigned DEST_W   = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic [NUM_PINS-1:0] irq_pin_i,
    input logic [NUM_PINS-1:0] cfg_level_i,
    input logic                req_valid_o,
    input logic [VEC_W-1:0]    req_vector_o,
    input logic [DEST_W-1:0]   req_dest_o,
    input logic [2:0]          req_dlv_mode_o,
    input logic                req_dest_mode_o,
    input logic                req_polarity_o,
    input logic                req_level_o,
    input logic                rsp_accept_i,
    input logic                rsp_reject_i,
    input logic [NUM_PINS-1:0] pending_o,
    input logic                stuck_warn_o,
    input logic                mode_err_o
);
    // R2: level lines mirror the sampled line
    a_r2_level_follows: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((pending_o & $past(cfg_level_i)) == ($past(irq_pin_i) & $past(cfg_level_i))));

    // R3: an edge request falls only after an accept
    a_r3_edge_fall_needs_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (|($past(pending_o) & ~pending_o & ~$past(cfg_level_i))) |-> $past(rsp_accept_i));

    // R6: request held until a response
    a_r6_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_o && !rsp_accept_i && !rsp_reject_i) |=>
        (req_valid_o && $stable(req_vector_o) && $stable(req_dest_o) &&
         $stable(req_dlv_mode_o) && $stable(req_dest_mode_o) &&
         $stable(req_polarity_o) && $stable(req_level_o)));

    // R6: a response retires the request
    a_r6_single_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_o && (rsp_accept_i || rsp_reject_i)) |=> !req_valid_o);

    // R9: mode 7 never requested
    a_r9_no_external_req: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req_valid_o) |-> (req_dlv_mode_o != 3'd7));

    // R9: error flag is sticky
    a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        mode_err_o |=> mode_err_o);

    // R8: warning rises only after a reject
    a_r8_warn_after_reject: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stuck_warn_o) |-> $past(rsp_reject_i));

    // R7: an accept clears the warning
    a_r7_accept_clears_warn: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_o && rsp_accept_i) |=> !stuck_warn_o);
endmodule

bind irq_dispatch_scanner irq_dispatch_scanner_chk #(
    .NUM_PINS (NUM_PINS),
    .VEC_W    (VEC_W),
    .DEST_W   (DEST_W)
) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .irq_pin_i       (irq_pin_i),
    .cfg_level_i     (cfg_level_i),
    .req_valid_o     (req_valid_o),
    .req_vector_o    (req_vector_o),
    .req_dest_o      (req_dest_o),
    .req_dlv_mode_o  (req_dlv_mode_o),
    .req_dest_mode_o (req_dest_mode_o),
    .req_polarity_o  (req_polarity_o),
    .req_level_o     (req_level_o),
    .rsp_accept_i    (rsp_accept_i),
    .rsp_reject_i    (rsp_reject_i),
    .pending_o       (pending_o),
    .stuck_warn_o    (stuck_warn_o),
    .mode_err_o      (mode_err_o)
);

// File: tb/test_irq_dispatch_scanner.sv
module test_irq_dispatch_scanner;
    localparam int N = 8;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic           rst_n;
    logic [N-1:0]   irq_pin_i;
    logic [N-1:0]   cfg_mask_i, cfg_level_i, cfg_polarity_i, cfg_dest_mode_i;
    logic [3*N-1:0] cfg_dlv_mode_i;
    logic [8*N-1:0] cfg_vector_i, cfg_dest_i;
    logic           req_valid_o;
    logic [7:0]     req_vector_o, req_dest_o;
    logic [2:0]     req_dlv_mode_o;
    logic           req_dest_mode_o, req_polarity_o, req_level_o;
    logic           rsp_accept_i, rsp_reject_i;
    logic [N-1:0]   pending_o, dlv_status_o;
    logic           stuck_warn_o, mode_err_o;

    irq_dispatch_scanner i_irq_dispatch_scanner (
        .clk(clk), .rst_n(rst_n), .irq_pin_i(irq_pin_i),
        .cfg_mask_i(cfg_mask_i), .cfg_level_i(cfg_level_i),
        .cfg_polarity_i(cfg_polarity_i), .cfg_dest_mode_i(cfg_dest_mode_i),
        .cfg_dlv_mode_i(cfg_dlv_mode_i), .cfg_vector_i(cfg_vector_i),
        .cfg_dest_i(cfg_dest_i), .req_valid_o(req_valid_o),
        .req_vector_o(req_vector_o), .req_dest_o(req_dest_o),
        .req_dlv_mode_o(req_dlv_mode_o), .req_dest_mode_o(req_dest_mode_o),
        .req_polarity_o(req_polarity_o), .req_level_o(req_level_o),
        .rsp_accept_i(rsp_accept_i), .rsp_reject_i(rsp_reject_i),
        .pending_o(pending_o), .dlv_status_o(dlv_status_o),
        .stuck_warn_o(stuck_warn_o), .mode_err_o(mode_err_o)
    );

    int errors = 0;
    int checks = 0;
    int n_deliv = 0;
    int rsp_delay = 3;
    bit rsp_kind = 1'b1;
    int exp_q[$];

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Monitor / responder: compares each request against the scoreboard
    initial begin
        rsp_accept_i = 1'b0;
        rsp_reject_i = 1'b0;
        forever begin
            @(negedge clk);
            if (rst_n && req_valid_o) begin
                logic [7:0] v0, d0;
                logic [2:0] m0;
                logic [2:0] f0;
                bit         held;
                int         pin;
                v0 = req_vector_o; d0 = req_dest_o; m0 = req_dlv_mode_o;
                f0 = {req_dest_mode_o, req_polarity_o, req_level_o};
                held = 1'b1;
                for (int k = 0; k < rsp_delay; k++) begin
                    @(negedge clk);
                    if (!req_valid_o || req_vector_o != v0 || req_dest_o != d0 ||
                        req_dlv_mode_o != m0 ||
                        {req_dest_mode_o, req_polarity_o, req_level_o} != f0) held = 1'b0;
                end
                chk(held, "R6 request held until response", {31'd0, held}, 32'd1);
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R4 unexpected request vector", {24'd0, v0}, 32'hFFFF);
                end else begin
                    pin = exp_q.pop_front();
                    chk(v0 == cfg_vector_i[pin*8 +: 8], "R4 R11 vector/order", {24'd0, v0},
                        {24'd0, cfg_vector_i[pin*8 +: 8]});
                    chk(d0 == cfg_dest_i[pin*8 +: 8] && m0 == cfg_dlv_mode_i[pin*3 +: 3] &&
                        f0 == {cfg_dest_mode_i[pin], cfg_polarity_i[pin], cfg_level_i[pin]},
                        "R11 request fields", {21'd0, d0, m0, f0},
                        {21'd0, cfg_dest_i[pin*8 +: 8], cfg_dlv_mode_i[pin*3 +: 3],
                         cfg_dest_mode_i[pin], cfg_polarity_i[pin], cfg_level_i[pin]});
                end
                rsp_accept_i = rsp_kind;
                rsp_reject_i = !rsp_kind;
                n_deliv++;
                @(negedge clk);
                rsp_accept_i = 1'b0;
                rsp_reject_i = 1'b0;
                chk(!req_valid_o, "R6 response retires request", {31'd0, req_valid_o}, 32'd0);
            end
        end
    end

    task automatic pulse(input int p);
        @(negedge clk) irq_pin_i[p] = 1'b1;
        @(negedge clk) irq_pin_i[p] = 1'b0;
    endtask

    task automatic settle();
        repeat (80) @(negedge clk);
    endtask

    task automatic summary();
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        int base;
        rst_n = 1'b0;
        irq_pin_i = '0;
        cfg_mask_i = '0; cfg_level_i = '0; cfg_polarity_i = '0; cfg_dest_mode_i = '0;
        cfg_dlv_mode_i = '0;
        for (int i = 0; i < N; i++) begin
            cfg_vector_i[i*8 +: 8] = 8'h40 + 8'(i);
            cfg_dest_i[i*8 +: 8]   = 8'h10 + 8'(i);
        end
        cfg_dest_mode_i[7] = 1'b1; cfg_polarity_i[7] = 1'b1; cfg_dlv_mode_i[7*3 +: 3] = 3'd1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk(pending_o == 0 && dlv_status_o == 0, "R1 pending/status after reset",
            {16'd0, pending_o, dlv_status_o}, 32'd0);
        chk(!req_valid_o && !stuck_warn_o && !mode_err_o, "R1 flags after reset",
            {29'd0, req_valid_o, stuck_warn_o, mode_err_o}, 32'd0);

        // R3 edge line 2
        exp_q.push_back(2);
        pulse(2);
        chk(pending_o[2] == 1'b1, "R3 pending kept after line falls", {31'd0, pending_o[2]}, 32'd1);
        settle();
        chk(pending_o[2] == 1'b0, "R3 accept clears edge pending", {31'd0, pending_o[2]}, 32'd0);
        chk(dlv_status_o[2] == 1'b0, "R7 status clear after accept", {31'd0, dlv_status_o[2]}, 32'd0);
        chk(exp_q.size() == 0, "R4 edge request delivered", exp_q.size(), 32'd0);

        // R5 masked line 5
        cfg_mask_i[5] = 1'b1;
        base = n_deliv;
        pulse(5);
        settle();
        chk(pending_o[5] == 1'b1, "R5 masked line stays pending", {31'd0, pending_o[5]}, 32'd1);
        chk(n_deliv == base, "R5 masked line not requested", n_deliv, base);

        // R2 level line 1
        cfg_level_i[1] = 1'b1;
        exp_q.push_back(1);
        @(negedge clk) irq_pin_i[1] = 1'b1;
        settle();
        chk(pending_o[1] == 1'b1, "R2 level pending kept after accept", {31'd0, pending_o[1]}, 32'd1);
        chk(exp_q.size() == 0, "R2 level request delivered", exp_q.size(), 32'd0);
        irq_pin_i[1] = 1'b0;
        @(negedge clk);
        chk(pending_o[1] == 1'b0, "R2 level pending follows line low", {31'd0, pending_o[1]}, 32'd0);
        cfg_level_i[1] = 1'b0;
        @(negedge clk);

        // R4 ascending order, lines 0, 3, 6 together; 7 carries distinct fields (R11)
        exp_q.push_back(0); exp_q.push_back(3); exp_q.push_back(6); exp_q.push_back(7);
        base = n_deliv;
        @(negedge clk) begin irq_pin_i[0] = 1'b1; irq_pin_i[3] = 1'b1; irq_pin_i[6] = 1'b1; irq_pin_i[7] = 1'b1; end
        @(negedge clk) irq_pin_i = '0;
        settle();
        chk(n_deliv == base + 4 && exp_q.size() == 0, "R4 four requests in order", n_deliv - base, 32'd4);

        // R10 start during a scan triggers a second pass
        rsp_delay = 10;
        exp_q.push_back(4); exp_q.push_back(1);
        pulse(4);
        repeat (6) @(negedge clk);
        pulse(1);
        settle();
        chk(exp_q.size() == 0 && pending_o[1] == 1'b0, "R10 latched rescan delivered line 1",
            {31'd0, pending_o[1]}, 32'd0);
        rsp_delay = 3;

        // R8 rejects and the stuck warning
        rsp_kind = 1'b0;
        for (int k = 1; k <= 6; k++) begin
            exp_q.push_back(0);
            pulse(0);
            settle();
            chk(pending_o[0] == 1'b1 && dlv_status_o[0] == 1'b1, "R8 reject keeps pending, sets status",
                {30'd0, pending_o[0], dlv_status_o[0]}, 32'd3);
            if (k == 5) chk(stuck_warn_o == 1'b0, "R8 no warning after 5 rejects", {31'd0, stuck_warn_o}, 32'd0);
            if (k == 6) chk(stuck_warn_o == 1'b1, "R8 warning after 6 rejects", {31'd0, stuck_warn_o}, 32'd1);
        end
        chk(exp_q.size() == 0, "R8 retries requested", exp_q.size(), 32'd0);
        rsp_kind = 1'b1;
        exp_q.push_back(0);
        pulse(0);
        settle();
        chk(pending_o[0] == 1'b0 && dlv_status_o[0] == 1'b0 && stuck_warn_o == 1'b0,
            "R7 accept clears status and warning",
            {29'd0, pending_o[0], dlv_status_o[0], stuck_warn_o}, 32'd0);

        // R9 external-controller mode
        cfg_dlv_mode_i[3*3 +: 3] = 3'd7;
        base = n_deliv;
        pulse(3);
        settle();
        chk(mode_err_o == 1'b1, "R9 mode error raised", {31'd0, mode_err_o}, 32'd1);
        chk(pending_o[3] == 1'b1 && n_deliv == base, "R9 line 3 not requested, still pending",
            {31'd0, pending_o[3]}, 32'd1);

        summary();
    end
endmodule